// File: doc/BRIEF.md
# Hysteretic Auto-Restart Supervisor

This block is the digital supervisor of an off-line switching regulator. It watches three comparator flags on the controller supply pin and an over-temperature flag. From these it decides three things: whether the power switch may be modulated, whether the high-voltage start-up bias source charges the supply capacitor, and whether a fault holds the switch off. The comparators, the bias source and the capacitor sit outside the block. Every flag arrives asynchronously and passes through a synchronizer before the block uses it.

At power-up the bias source charges the capacitor. The first time the supply pin reaches the upper threshold, switching starts and the bias source turns off. If the feedback current is lost, the pin sags to the lower threshold. The block then stops the switch and enters auto-restart: the bias source recharges the pin and lets it discharge, which holds it between the two thresholds. Switching is allowed again only on the eighth recharge. This keeps the dissipation during a fault to a small duty cycle.

An over-temperature flag latches the switch off. Hysteretic cycling continues while the latch is set. Only a drop below the power-up reset level or the block reset clears the latch and the cycle counter.

Top module: `asr_supervisor`

## Requirements
- R1: While rst_n is low and in the cycle after it, mode_o is 2'b00 (start-up), bias_en_o is 1, sw_en_o is 0 and standby_o is 0. The block reset also clears the thermal latch.
- R2: In start-up, the first rising edge of the upper-threshold flag sets sw_en_o to 1, sets bias_en_o to 0 and sets mode_o to 2'b01 (normal).
- R3: In normal mode bias_en_o stays 0 while sw_en_o is 1. A held or repeated upper-threshold flag leaves the outputs unchanged.
- R4: In normal mode, a rising edge of the lower-threshold flag clears sw_en_o, sets bias_en_o and standby_o, and sets mode_o to 2'b10 (auto-restart).
- R5: In modes 2'b10 and 2'b11, a rising edge of the lower-threshold flag sets bias_en_o and a rising edge of the upper-threshold flag clears it.
- R6: After entering auto-restart, sw_en_o stays 0 through the first seven upper-threshold rising edges. The eighth returns the block to mode 2'b01 with sw_en_o at 1. Each window of switching is therefore preceded by exactly eight recharge cycles.
- R7: A high over-temperature flag in start-up, normal or auto-restart moves the block to mode 2'b11 (latched) with sw_en_o at 0 and standby_o at 1.
- R8: In mode 2'b11, hysteretic cycling per R5 continues, sw_en_o never rises and the mode stays 2'b11 until a power-up reset, even after the over-temperature flag falls.
- R9: A high power-up-reset flag returns the block to mode 2'b00 with bias_en_o at 1 and clears both the thermal latch and the restart cycle count. The next upper-threshold edge then enables switching at once, and a later auto-restart again needs eight full cycles.
- R10: Each flag passes through a two-flop synchronizer, and edge-triggered events act only on a rising edge. An output responds on the third clock edge after a flag changes. A flag held high is acted on once.
- R11: mode_o encodes 2'b00 start-up, 2'b01 normal, 2'b10 auto-restart, 2'b11 latched. standby_o is 1 exactly in the last two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vc_hi_i | input | 1 | Supply pin at or above upper threshold (asynchronous) |
| vc_lo_i | input | 1 | Supply pin below lower threshold (asynchronous) |
| vc_por_i | input | 1 | Supply pin below power-up reset level (asynchronous) |
| hot_i | input | 1 | Over-temperature flag (asynchronous) |
| bias_en_o | output | 1 | Enable for the high-voltage start-up bias source |
| sw_en_o | output | 1 | Enable for the modulator and power switch |
| standby_o | output | 1 | Low-current standby indication |
| mode_o | output | 2 | Current mode code |

## Verification
A corrupted restart count shows at the ports as a switching window after fewer or more than eight upper-threshold edges. That error becomes visible at the first window after the fault and is caught by counting edges between windows of a free-running capacitor model. A wrong mode register shows within three clock edges of the next flag edge: bias_en_o or sw_en_o takes the wrong level. A thermal latch that fails to hold is exposed by sw_en_o rising during the hysteretic cycles after the over-temperature flag drops. A missing clear on power-up reset is exposed by a later auto-restart releasing early.

// File: rtl/asr_pkg.sv
// Shared types for the auto-restart supervisor.
package asr_pkg;
    // Mode code; the values are visible on mode_o.
    typedef enum logic [1:0] {
        MODE_BOOT  = 2'b00,
        MODE_RUN   = 2'b01,
        MODE_RETRY = 2'b10,
        MODE_HALT  = 2'b11
    } asr_mode_e;

    // Index of each flag in the synchronizer bank.
    localparam int FLAG_HI   = 0;
    localparam int FLAG_LO   = 1;
    localparam int FLAG_POR  = 2;
    localparam int FLAG_HOT  = 3;
    localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/asr_sync.sv
// Brings one asynchronous comparator flag into the clock domain.
// Produces its level and a one-cycle pulse on each rising edge.
// Assumes STAGES >= 2. The output is low during reset.
module asr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw flag through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], raw};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/asr_cycle_cnt.sv
// Counts recharge cycles during auto-restart.
// last is high on the final count of the divide ratio.
// Assumes the controller clears the count or steps past last to wrap it.
module asr_cycle_cnt #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] TOP = W'(DIV - 1);

    logic [W-1:0] cnt;

    // Step the count, wrapping after the last value; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (step)      cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
    end

    assign last = (cnt == TOP);
endmodule

// File: rtl/asr_ctrl.sv
// Mode controller: start-up, normal switching, auto-restart and thermal latch.
// Assumes the inputs are already synchronized.
// Power-up reset outranks over-temperature, which outranks threshold edges.
module asr_ctrl
    import asr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hi_rise,
    input  logic      lo_rise,
    input  logic      por_lvl,
    input  logic      hot_lvl,
    input  logic      cnt_last,
    output logic      cnt_step,
    output logic      cnt_clr,
    output logic      bias_en,
    output logic      sw_en,
    output logic      standby,
    output logic [1:0] mode
);
    asr_mode_e state, state_nx;
    logic      charging;

    // Next-mode decision.
    always_comb begin
        state_nx = state;
        if (por_lvl) begin
            state_nx = MODE_BOOT;
        end else begin
            case (state)
                MODE_BOOT:  if (hot_lvl) state_nx = MODE_HALT;
                            else if (hi_rise) state_nx = MODE_RUN;
                MODE_RUN:   if (hot_lvl) state_nx = MODE_HALT;
                            else if (lo_rise) state_nx = MODE_RETRY;
                MODE_RETRY: if (hot_lvl) state_nx = MODE_HALT;
                            else if (hi_rise && cnt_last) state_nx = MODE_RUN;
                default:    state_nx = MODE_HALT;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_BOOT;
        else        state <= state_nx;
    end

    // Hysteretic charge flag: on at the lower edge, off at the upper edge.
    always_ff @(posedge clk) begin
        if (!rst_n || por_lvl) charging <= 1'b1;
        else if (lo_rise)      charging <= 1'b1;
        else if (hi_rise)      charging <= 1'b0;
    end

    // Counter control: one step per completed recharge in auto-restart.
    always_comb begin
        cnt_step = (state == MODE_RETRY) && hi_rise && !por_lvl && !hot_lvl;
        cnt_clr  = por_lvl;
    end

    // Output decode.
    always_comb begin
        sw_en   = (state == MODE_RUN);
        standby = (state == MODE_RETRY) || (state == MODE_HALT);
        case (state)
            MODE_BOOT: bias_en = 1'b1;
            MODE_RUN:  bias_en = 1'b0;
            default:   bias_en = charging;
        endcase
        mode = state;
    end
endmodule

// File: rtl/asr_supervisor.sv
// Top of the auto-restart supervisor.
// Synchronizes the four supply-pin and temperature flags, counts recharge
// cycles, and drives the bias, switch and status outputs.
// Assumes the flags come from free-running analog comparators.
module asr_supervisor
    import asr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RESTART_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vc_hi_i,
    input  logic       vc_lo_i,
    input  logic       vc_por_i,
    input  logic       hot_i,
    output logic       bias_en_o,
    output logic       sw_en_o,
    output logic       standby_o,
    output logic [1:0] mode_o
);
    logic [NUM_FLAGS-1:0] raw_flags, flag_lvl, flag_rise;
    logic hi_rise, lo_rise, por_lvl, ot_lvl;
    logic cnt_step, cnt_clr, cnt_last;

    assign raw_flags[FLAG_HI]  = vc_hi_i;
    assign raw_flags[FLAG_LO]  = vc_lo_i;
    assign raw_flags[FLAG_POR] = vc_por_i;
    assign raw_flags[FLAG_HOT] = hot_i;

    // One synchronizer per flag.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sync
        asr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_flags[i]),
            .lvl  (flag_lvl[i]),
            .rise (flag_rise[i])
        );
    end

    assign hi_rise = flag_rise[FLAG_HI];
    assign lo_rise = flag_rise[FLAG_LO];
    assign por_lvl = flag_lvl[FLAG_POR];
    assign ot_lvl  = flag_lvl[FLAG_HOT];

    asr_cycle_cnt #(.DIV(RESTART_DIV)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .step (cnt_step),
        .last (cnt_last)
    );

    asr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_rise (hi_rise),
        .lo_rise (lo_rise),
        .por_lvl (por_lvl),
        .hot_lvl (ot_lvl),
        .cnt_last(cnt_last),
        .cnt_step(cnt_step),
        .cnt_clr (cnt_clr),
        .bias_en (bias_en_o),
        .sw_en   (sw_en_o),
        .standby (standby_o),
        .mode    (mode_o)
    );
endmodule

// File: rtl/asr_supervisor_chk.sv
// Property checker for asr_supervisor. It is attached by the bind at the end of this file.
module asr_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_lvl,
    input logic       ot_lvl,
    input logic       cnt_last,
    input logic       bias_en,
    input logic       sw_en,
    input logic       standby,
    input logic [1:0] mode
);
    p_boot_bias_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (bias_en && !sw_en && !standby));

    p_sw_bias_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> !bias_en);

    p_standby_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (standby && !sw_en));

    p_release_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $past(mode) == 2'b10) |-> $past(cnt_last));

    p_hot_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_lvl && !por_lvl) |=> (mode == 2'b11 && !sw_en));

    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !por_lvl) |=> (mode == 2'b11));

    p_por_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        por_lvl |=> (mode == 2'b00 && bias_en));
endmodule

bind asr_supervisor asr_supervisor_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_lvl (por_lvl),
    .ot_lvl  (ot_lvl),
    .cnt_last(cnt_last),
    .bias_en (bias_en_o),
    .sw_en   (sw_en_o),
    .standby (standby_o),
    .mode    (mode_o)
);

// File: tb/asr_supervisor_tb.sv
`timescale 1ns/1ps
module asr_supervisor_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic dir_hi = 0, dir_lo = 0, dir_por = 0, dir_hot = 0;
    logic model_on = 0, fb_ok = 0;
    int   vcap = 500;
    logic vc_hi, vc_lo, vc_por;
    logic bias_en, sw_en, standby;
    logic [1:0] mode;

    int total = 0, bad = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];
    bit         done = 0;

    // Capacitor model: the flags follow vcap when the model is active.
    assign vc_hi  = model_on ? (vcap >= 570) : dir_hi;
    assign vc_lo  = model_on ? (vcap < 470)  : dir_lo;
    assign vc_por = model_on ? 1'b0          : dir_por;

    asr_supervisor u_dut (
        .clk(clk), .rst_n(rst_n), .vc_hi_i(vc_hi), .vc_lo_i(vc_lo),
        .vc_por_i(vc_por), .hot_i(dir_hot), .bias_en_o(bias_en),
        .sw_en_o(sw_en), .standby_o(standby), .mode_o(mode)
    );

    // Model integration: bias charges, load discharges unless feedback holds.
    always @(negedge clk) begin
        if (!model_on) vcap <= 500;
        else if (bias_en) vcap <= vcap + 3;
        else if (!(sw_en && fb_ok)) vcap <= vcap - 1;
    end

    // Window bookkeeping: upper-threshold edges between switching windows.
    int hi_n = 0, win_n = 0, gap_bad = 0, gap_seen = 0;
    logic hi_prev = 0, sw_prev = 0;
    always @(negedge clk) begin
        if (model_on) begin
            if (vc_hi && !hi_prev) hi_n = hi_n + 1;
            if (sw_en && !sw_prev) begin
                if (win_n > 0) begin
                    gap_seen = gap_seen + 1;
                    if (hi_n != 8) begin
                        gap_bad = gap_bad + 1;
                        $display("note: window gap act=%0d exp=8", hi_n);
                    end
                end
                win_n = win_n + 1;
                hi_n = 0;
            end
        end
        hi_prev = vc_hi;
        sw_prev = sw_en;
    end

    // Monitor: pops expected items and compares them with the outputs after the edge.
    initial forever begin
        @(posedge clk);
        #1;
        while (exp_q.size() > 0) begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({bias_en, sw_en, standby, mode} !== e) begin
                bad++;
                $display("FAIL %s act={bias,sw,stby,mode}=%b exp=%b", t,
                         {bias_en, sw_en, standby, mode}, e);
            end
        end
    end

    task automatic expect_out(input logic b, input logic s, input logic st,
                              input logic [1:0] m, input string t);
        exp_q.push_back({b, s, st, m});
        tag_q.push_back(t);
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string t, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", t, act, expv);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_hi(input logic v); @(negedge clk); dir_hi = v; settle(); endtask
    task automatic set_lo(input logic v); @(negedge clk); dir_lo = v; settle(); endtask
    task automatic set_por(input logic v); @(negedge clk); dir_por = v; settle(); endtask
    task automatic set_hot(input logic v); @(negedge clk); dir_hot = v; settle(); endtask

    // One discharge-charge cycle of the supply pin; checks bias after each edge.
    task automatic hyst_cycle(input logic [1:0] m_after, input logic sw_after,
                              input string t);
        logic [1:0] m_mid;
        m_mid = (m_after == 2'b01) ? 2'b10 : m_after;
        set_hi(0);
        set_lo(1);
        expect_out(1, 0, 1, m_mid, {t, " R5 bias on at lower edge"});
        set_lo(0);
        set_hi(1);
        expect_out(sw_after ? 1'b0 : 1'b0, sw_after, !sw_after, m_after,
                   {t, " R5/R6 after upper edge"});
    endtask

    task automatic por_pulse();
        set_por(1);
        set_hi(0);
        set_lo(0);
        set_por(0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(1, 0, 0, 2'b00, "R1 reset state");
        @(negedge clk); rst_n = 1;
        settle();
        expect_out(1, 0, 0, 2'b00, "R1 after reset release");

        // R2: first upper crossing enables switching.
        set_hi(1);
        expect_out(0, 1, 0, 2'b01, "R2 first upper crossing");
        repeat (10) @(negedge clk);
        expect_out(0, 1, 0, 2'b01, "R3 held upper flag, R10 acted once");

        // R4 with R10 latency check.
        set_hi(0);
        @(negedge clk); dir_lo = 1;
        repeat (2) @(negedge clk);
        chk(sw_en == 1'b1, "R10 no response before third edge", sw_en, 1);
        @(negedge clk);
        chk(sw_en == 1'b0, "R10 response on third edge", sw_en, 0);
        settle();
        expect_out(1, 0, 1, 2'b10, "R4 lower crossing enters auto-restart");
        set_lo(0);
        expect_out(1, 0, 1, 2'b10, "R5 bias held while charging");
        set_hi(1);
        expect_out(0, 0, 1, 2'b10, "R6 cycle 1 no switching");
        repeat (12) @(negedge clk);
        expect_out(0, 0, 1, 2'b10, "R10 held upper flag does not step");
        for (int c = 2; c <= 7; c++) hyst_cycle(2'b10, 0, "R6 cycles 2-7 count");
        hyst_cycle(2'b01, 1, "R6 eighth cycle");

        // R7/R8: thermal latch from normal.
        set_hot(1);
        expect_out(0, 0, 1, 2'b11, "R7 thermal latch from normal");
        set_hot(0);
        expect_out(0, 0, 1, 2'b11, "R8 latch holds after flag drops");
        for (int c = 0; c < 9; c++) hyst_cycle(2'b11, 0, "R8 latched cycling");

        // R9: power-up reset clears the latch; next crossing switches at once.
        set_por(1);
        expect_out(1, 0, 0, 2'b00, "R9 por returns to start-up");
        set_hi(0);
        set_por(0);
        set_hi(1);
        expect_out(0, 1, 0, 2'b01, "R9 immediate enable after por");

        // R9: por clears a partial restart count.
        set_hi(0);
        set_lo(1);
        expect_out(1, 0, 1, 2'b10, "R4 second entry to auto-restart");
        set_lo(0);
        set_hi(1);
        hyst_cycle(2'b10, 0, "R9 pre-por cycle");
        hyst_cycle(2'b10, 0, "R9 pre-por cycle");
        por_pulse();
        expect_out(1, 0, 0, 2'b00, "R9 start-up after por pulse");
        set_hi(1);
        expect_out(0, 1, 0, 2'b01, "R9 enable after por pulse");
        set_hi(0);
        set_lo(1);
        set_lo(0);
        set_hi(1);
        for (int c = 2; c <= 7; c++) hyst_cycle(2'b10, 0, "R9 count cleared, no early release");
        hyst_cycle(2'b01, 1, "R9 release on eighth after clear");

        // R7 from start-up, then R1 block reset clears the latch.
        por_pulse();
        set_hot(1);
        expect_out(1, 0, 1, 2'b11, "R7 thermal latch from start-up");
        set_hot(0);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        expect_out(1, 0, 0, 2'b00, "R1 block reset clears latch");
        @(negedge clk); rst_n = 1;
        settle();
        expect_out(1, 0, 0, 2'b00, "R11 start-up code after reset");

        // R6: free-running capacitor model with lost feedback.
        @(negedge clk);
        model_on = 1;
        fb_ok = 0;
        repeat (4000) @(negedge clk);
        chk(win_n >= 3, "R6 switching windows observed", win_n, 3);
        chk(gap_seen >= 2 && gap_bad == 0, "R6 eight cycles per window", gap_bad, 0);
        model_on = 0;

        done = 1;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule